// File: doc/BRIEF.md
# Dual-Clock Sequential Field Buffer

This block is a field-memory style buffer with a write port and a read port, each running on its own clock. Neither port takes an address. Each port keeps a pointer that steps through the storage one word at a time, and a synchronous clear on the same side returns that pointer to word 0. The block is meant for video-style streams: a producer writes a line or field in order, and a consumer replays it later, possibly more than once.

The controls that advance a pointer are separate from the controls that gate its data. A write can be masked, so the word stays as it was while the pointer still moves. A read can be hidden, so the output is forced to zero while the pointer still moves. Together these allow non-linear access, such as skipping pixels or overwriting only part of a field.

A static strap sets whether all eight control inputs are active-high or active-low. A static mode input splits the storage into two halves, and each port picks its half at its own clear. The read clock can also be looped back out, gated by an enable and optionally inverted.

Top module: `fm_field_buffer`

## Requirements
- R1: `rst_n` is sampled low on a rising edge of each clock. It returns both pointers to word 0 and both frame selections to frame 0, and it clears the read register. While output enable is active, `dout` then reads 0, and the first read after reset returns word 0.
- R2: On a `wclk` rising edge where write enable is active, write clear is inactive and input enable is active, `din` is stored at the write pointer and the pointer advances by one.
- R3: On a `wclk` rising edge where write enable is active and input enable is inactive, the stored word is left unchanged and the write pointer still advances by one.
- R4: On an `rclk` rising edge where read enable is active and read clear is inactive, the word at the read pointer is loaded into the read register and the pointer advances by one. The word appears on `dout` one read-clock cycle after the enable was applied. With read enable inactive, `dout` holds its value.
- R5: While output enable is inactive, `dout` is 0. The read pointer still advances on read enable, so the word it passes over is skipped.
- R6: Write clear and read clear each set their own pointer to 0 on their own clock edge. On that edge no word is written or read, even if the enable is active.
- R7: With `pol_low` = 1, write enable, input enable, write clear, read enable, output enable, read clear, loop-out enable and loop-out invert are all active at logic 0. With `pol_low` = 0 they are active at logic 1.
- R8: With `two_frame` = 0, each pointer covers all DEPTH words and wraps from DEPTH-1 to 0.
- R9: With `two_frame` = 1, the port's frame bit is the most significant address bit and the pointer covers DEPTH/2 words, wrapping inside the frame. A port samples its frame select only on its own clear, and the value holds until that port's next clear.
- R10: `rclk_out` is 0 while loop-out enable is inactive. When loop-out enable is active, `rclk_out` equals `rclk`, or its complement when loop-out invert is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Global reset, active low, sampled on each clock |
| pol_low | input | 1 | Static polarity strap; 1 makes the controls active low |
| two_frame | input | 1 | Static mode: 1 splits the storage into two frames |
| din | input | DW | Write data |
| wen | input | 1 | Write pointer step enable |
| ie | input | 1 | Write data gate (0-active level masks the write) |
| wrst | input | 1 | Write pointer clear |
| wfsel | input | 1 | Write frame select, taken at write clear |
| ren | input | 1 | Read pointer step enable |
| oe | input | 1 | Read data output gate |
| rrst | input | 1 | Read pointer clear |
| rfsel | input | 1 | Read frame select, taken at read clear |
| lo_en | input | 1 | Read-clock loop-out enable |
| lo_inv | input | 1 | Read-clock loop-out invert |
| dout | output | DW | Read data, zero while output gate is inactive |
| rclk_out | output | 1 | Looped-out read clock |

## Verification
A write takes effect on the first `wclk` rising edge after the inputs are set up. Its result can be seen only through a later read. A read word appears on `dout` after the `rclk` rising edge that follows the enable, so the bench drives each read on a falling edge of `rclk` and samples `dout` on the next falling edge. The output gate and the loop-out clock are combinational from the inputs, so they are checked one nanosecond after a clock edge within the same cycle. Pointer clears, masked writes and skipped reads are checked through the words that later reads return.

// File: rtl/fm_pkg.sv
package fm_pkg;

  // Control inputs, in the order the polarity decoder sees them.
  typedef struct packed {
    logic wen;
    logic ie;
    logic wrst;
    logic ren;
    logic oe;
    logic rrst;
    logic lo_en;
    logic lo_inv;
  } fm_ctl_t;

  localparam int unsigned FM_CTL_W = $bits(fm_ctl_t);

endpackage

// File: rtl/fm_pol_decode.sv
module fm_pol_decode #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] raw,
  input  logic         pol_low,
  output logic [N-1:0] act
);

  // A set strap turns active-low controls into active-high internal strobes.
  assign act = raw ^ {N{pol_low}};

endmodule

// File: rtl/fm_seq_port.sv
module fm_seq_port #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          two_frame,
  input  logic          step,
  input  logic          clear,
  input  logic          fsel,
  output logic [AW-1:0] addr,
  output logic          access
);

  logic [AW-1:0] ptr;
  logic [AW-1:0] ptr_nx;
  logic          frame;

  // In two-frame mode the pointer MSB is forced to zero so it wraps in half.
  always_comb begin
    ptr_nx = ptr + 1'b1;
    if (two_frame) ptr_nx[AW-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      frame <= 1'b0;
    end else if (clear) begin
      ptr   <= '0;
      frame <= fsel;
    end else if (step) begin
      ptr   <= ptr_nx;
    end
  end

  assign addr   = two_frame ? {frame, ptr[AW-2:0]} : ptr;
  assign access = rst_n & step & ~clear;

endmodule

// File: rtl/fm_dpram.sv
module fm_dpram #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with its own clock and synchronous output reset.
  always_ff @(posedge rclk) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/fm_field_buffer.sv
module fm_field_buffer #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          pol_low,
  input  logic          two_frame,
  input  logic [DW-1:0] din,
  input  logic          wen,
  input  logic          ie,
  input  logic          wrst,
  input  logic          wfsel,
  input  logic          ren,
  input  logic          oe,
  input  logic          rrst,
  input  logic          rfsel,
  input  logic          lo_en,
  input  logic          lo_inv,
  output logic [DW-1:0] dout,
  output logic          rclk_out
);
  import fm_pkg::*;

  fm_ctl_t raw_c;
  fm_ctl_t act_c;
  logic [FM_CTL_W-1:0] act_bits;

  assign raw_c = '{wen: wen, ie: ie, wrst: wrst, ren: ren, oe: oe,
                   rrst: rrst, lo_en: lo_en, lo_inv: lo_inv};

  fm_pol_decode #(.N(FM_CTL_W)) u_pol (
    .raw     (raw_c),
    .pol_low (pol_low),
    .act     (act_bits)
  );
  assign act_c = act_bits;

  logic wen_on, ie_on, wrst_on, ren_on, oe_on, rrst_on, lo_en_on, lo_inv_on;
  assign wen_on    = act_c.wen;
  assign ie_on     = act_c.ie;
  assign wrst_on   = act_c.wrst;
  assign ren_on    = act_c.ren;
  assign oe_on     = act_c.oe;
  assign rrst_on   = act_c.rrst;
  assign lo_en_on  = act_c.lo_en;
  assign lo_inv_on = act_c.lo_inv;

  logic [AW-1:0] waddr, raddr;
  logic          w_access, r_access;
  logic [DW-1:0] rd_q;

  fm_seq_port #(.AW(AW)) u_wport (
    .clk       (wclk),
    .rst_n     (rst_n),
    .two_frame (two_frame),
    .step      (wen_on),
    .clear     (wrst_on),
    .fsel      (wfsel),
    .addr      (waddr),
    .access    (w_access)
  );

  fm_seq_port #(.AW(AW)) u_rport (
    .clk       (rclk),
    .rst_n     (rst_n),
    .two_frame (two_frame),
    .step      (ren_on),
    .clear     (rrst_on),
    .fsel      (rfsel),
    .addr      (raddr),
    .access    (r_access)
  );

  fm_dpram #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .wclk  (wclk),
    .we    (w_access & ie_on),
    .waddr (waddr),
    .wdata (din),
    .rclk  (rclk),
    .rst_n (rst_n),
    .re    (r_access),
    .raddr (raddr),
    .q     (rd_q)
  );

  assign dout     = oe_on ? rd_q : '0;
  assign rclk_out = lo_en_on ? (rclk ^ lo_inv_on) : 1'b0;

endmodule

// File: rtl/fm_field_buffer_chk.sv
module fm_field_buffer_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          two_frame,
  input logic          wen_on,
  input logic          wrst_on,
  input logic          ren_on,
  input logic          rrst_on,
  input logic          oe_on,
  input logic          lo_en_on,
  input logic [AW-1:0] waddr,
  input logic [AW-1:0] raddr,
  input logic [DW-1:0] dout,
  input logic          rclk_out
);

  // R3
  wptr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen_on && !wrst_on && !two_frame) |=> (waddr == $past(waddr) + 1'b1));

  // R6
  wptr_clear_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wrst_on |=> (waddr[AW-2:0] == '0));

  // R4
  rptr_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren_on && !rrst_on && !two_frame) |=> (raddr == $past(raddr) + 1'b1));

  // R6
  rptr_clear_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rrst_on |=> (raddr[AW-2:0] == '0));

  // R5
  dout_gate_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !oe_on |-> (dout == '0));

  // R4
  dout_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (oe_on && $past(oe_on) && !$past(ren_on) && $past(rst_n)) |-> $stable(dout));

  // R10
  loop_off_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !lo_en_on |-> (rclk_out == 1'b0));

endmodule

bind fm_field_buffer fm_field_buffer_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk      (wclk),
  .rclk      (rclk),
  .rst_n     (rst_n),
  .two_frame (two_frame),
  .wen_on    (wen_on),
  .wrst_on   (wrst_on),
  .ren_on    (ren_on),
  .rrst_on   (rrst_on),
  .oe_on     (oe_on),
  .lo_en_on  (lo_en_on),
  .waddr     (waddr),
  .raddr     (raddr),
  .dout      (dout),
  .rclk_out  (rclk_out)
);

// File: tb/fm_field_buffer_tb.sv
module fm_field_buffer_tb;
  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  always #5 wclk = ~wclk;
  initial begin
    #2;
    forever #5 rclk = ~rclk;
  end

  logic          rst_n = 1'b0;
  logic          pol_low = 1'b0, two_frame = 1'b0;
  logic [DW-1:0] din = '0;
  logic          wen = 1'b0, ie = 1'b0, wrst = 1'b0, wfsel = 1'b0;
  logic          ren = 1'b0, oe = 1'b0, rrst = 1'b0, rfsel = 1'b0;
  logic          lo_en = 1'b0, lo_inv = 1'b0;
  logic [DW-1:0] dout;
  logic          rclk_out;

  fm_field_buffer #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .pol_low(pol_low),
    .two_frame(two_frame), .din(din), .wen(wen), .ie(ie), .wrst(wrst),
    .wfsel(wfsel), .ren(ren), .oe(oe), .rrst(rrst), .rfsel(rfsel),
    .lo_en(lo_en), .lo_inv(lo_inv), .dout(dout), .rclk_out(rclk_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic pol = 1'b0;
  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] q;

  function automatic logic lv(input logic a);
    return a ^ pol;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    wen = lv(1'b0); ie = lv(1'b1); wrst = lv(1'b0);
    ren = lv(1'b0); oe = lv(1'b1); rrst = lv(1'b0);
    lo_en = lv(1'b0); lo_inv = lv(1'b0);
  endtask

  // Caller stands on a falling wclk edge; the next rising edge acts.
  task automatic w_cyc(input logic en, input logic g, input logic rs, input logic [DW-1:0] d);
    wen = lv(en); ie = lv(g); wrst = lv(rs); din = d;
    @(negedge wclk);
  endtask

  // Caller stands on a falling rclk edge; result sampled one cycle later.
  task automatic r_cyc(input logic en, input logic g, input logic rs, output logic [DW-1:0] rq);
    ren = lv(en); oe = lv(g); rrst = lv(rs);
    @(negedge rclk);
    rq = dout;
  endtask

  task automatic do_reset(input logic p, input logic tf);
    pol = p; pol_low = p; two_frame = tf;
    wfsel = 1'b0; rfsel = 1'b0;
    idle_all();
    rst_n = 1'b0;
    repeat (3) @(negedge wclk);
    rst_n = 1'b1;
    @(negedge rclk);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    chk("R1 dout after reset", dout, 0);
    chk("R10 loop-out off after reset", rclk_out, 0);
    @(negedge wclk);
    w_cyc(1, 1, 0, 16'h1234);
    w_cyc(0, 1, 0, 0);
    @(negedge rclk);
    r_cyc(1, 1, 0, q);
    chk("R1 first read is word 0", q, 16'h1234);
  endtask

  task automatic t_basic();
    do_reset(1'b0, 1'b0);
    @(negedge wclk);
    for (int i = 0; i < DEPTH; i++) begin
      mdl[i] = 16'hA000 + 16'(i * 3);
      w_cyc(1, 1, 0, mdl[i]);
    end
    mdl[0] = 16'hBEEF;
    w_cyc(1, 1, 0, 16'hBEEF);   // R8 write wrap onto word 0
    w_cyc(0, 1, 0, 0);
    @(negedge rclk);
    for (int i = 0; i < DEPTH; i++) begin
      r_cyc(1, 1, 0, q);
      chk("R2 R4 sequential read", q, mdl[i]);
    end
    r_cyc(1, 1, 0, q);
    chk("R8 read wrap to word 0", q, mdl[0]);
    r_cyc(0, 1, 0, q);
    chk("R4 hold with read enable off", q, mdl[0]);
  endtask

  task automatic t_mask();
    do_reset(1'b0, 1'b0);
    @(negedge wclk);
    for (int i = 0; i < DEPTH; i++) begin
      mdl[i] = 16'h5100 + 16'(i);
      w_cyc(1, 1, 0, mdl[i]);
    end
    w_cyc(1, 1, 1, 16'hFFFF);
    for (int i = 0; i < DEPTH; i++) begin
      logic g;
      g = (i % 2) == 0;
      if (g) mdl[i] = 16'h7700 + 16'(i);
      w_cyc(1, g, 0, 16'h7700 + 16'(i));
    end
    w_cyc(0, 1, 0, 0);
    @(negedge rclk);
    r_cyc(0, 1, 1, q);
    for (int i = 0; i < DEPTH; i++) begin
      r_cyc(1, 1, 0, q);
      chk("R3 masked write keeps word", q, mdl[i]);
    end
  endtask

  task automatic t_skip();
    r_cyc(0, 1, 1, q);
    r_cyc(1, 0, 0, q);
    chk("R5 hidden read drives zero", q, 0);
    r_cyc(1, 1, 0, q);
    chk("R5 skipped word passed over", q, mdl[1]);
    r_cyc(0, 0, 0, q);
    chk("R5 output gated to zero", q, 0);
    r_cyc(0, 1, 0, q);
    chk("R5 data back when gate reopens", q, mdl[1]);
  endtask

  task automatic t_clear();
    do_reset(1'b0, 1'b0);
    @(negedge wclk);
    for (int i = 0; i < 3; i++) begin
      mdl[i] = 16'hC000 + 16'(i);
      w_cyc(1, 1, 0, mdl[i]);
    end
    w_cyc(1, 1, 1, 16'hDEAD);   // clear edge: no write at word 3
    mdl[0] = 16'h0C0C;
    w_cyc(1, 1, 0, 16'h0C0C);
    w_cyc(0, 1, 0, 0);
    @(negedge rclk);
    r_cyc(0, 1, 1, q);
    for (int i = 0; i < 4; i++) begin
      r_cyc(1, 1, 0, q);
      chk("R6 write clear and no write on clear edge", q, mdl[i]);
    end
    r_cyc(1, 1, 1, q);
    chk("R6 no read on read clear edge", q, mdl[3]);
    r_cyc(1, 1, 0, q);
    chk("R6 read restarts at word 0", q, mdl[0]);
  endtask

  task automatic t_pol();
    do_reset(1'b1, 1'b0);
    chk("R7 active-low: loop-out off at raw 1", rclk_out, 0);
    @(negedge wclk);
    for (int i = 0; i < 4; i++) begin
      mdl[i] = 16'h3C00 + 16'(i * 7);
      w_cyc(1, 1, 0, mdl[i]);
    end
    w_cyc(0, 1, 0, 0);
    @(negedge rclk);
    r_cyc(0, 1, 1, q);
    for (int i = 0; i < 2; i++) begin
      r_cyc(1, 1, 0, q);
      chk("R7 active-low read", q, mdl[i]);
    end
    ren = 1'b1; oe = 1'b0; rrst = 1'b1;   // raw levels: idle read, gate on
    @(negedge rclk);
    chk("R7 raw high is inactive", dout, mdl[1]);
    r_cyc(1, 1, 0, q);
    chk("R7 active-low read continues", q, mdl[2]);
  endtask

  task automatic t_two();
    do_reset(1'b0, 1'b1);
    @(negedge wclk);
    wfsel = 1'b1;
    w_cyc(0, 1, 1, 0);
    for (int i = 0; i < HALF; i++) begin
      if (i == 2) wfsel = 1'b0;   // must not move the frame
      mdl[HALF + i] = 16'hF100 + 16'(i);
      w_cyc(1, 1, 0, mdl[HALF + i]);
    end
    w_cyc(0, 1, 1, 0);           // frame 0 taken here
    for (int i = 0; i <= HALF; i++) begin
      mdl[i % HALF] = 16'hF000 + 16'(i);
      w_cyc(1, 1, 0, 16'hF000 + 16'(i));
    end
    w_cyc(0, 1, 0, 0);
    @(negedge rclk);
    rfsel = 1'b1;
    r_cyc(0, 1, 1, q);
    rfsel = 1'b0;
    for (int i = 0; i < HALF; i++) begin
      r_cyc(1, 1, 0, q);
      chk("R9 frame 1 read", q, mdl[HALF + i]);
    end
    r_cyc(1, 1, 0, q);
    chk("R9 wrap inside frame 1", q, mdl[HALF]);
    r_cyc(0, 1, 1, q);
    r_cyc(1, 1, 0, q);
    chk("R9 frame 0 word 0 after write wrap", q, mdl[0]);
    r_cyc(1, 1, 0, q);
    chk("R9 frame 0 word 1", q, mdl[1]);
  endtask

  task automatic t_loop();
    lo_en = lv(1'b1); lo_inv = lv(1'b0);
    @(posedge rclk); #1;
    chk("R10 loop-out follows high", rclk_out, 1);
    @(negedge rclk); #1;
    chk("R10 loop-out follows low", rclk_out, 0);
    lo_inv = lv(1'b1);
    @(posedge rclk); #1;
    chk("R10 inverted loop-out high phase", rclk_out, 0);
    @(negedge rclk); #1;
    chk("R10 inverted loop-out low phase", rclk_out, 1);
    lo_en = lv(1'b0);
    #1;
    chk("R10 loop-out disabled", rclk_out, 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_mask();
    t_skip();
    t_clear();
    t_pol();
    t_two();
    t_loop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule